// File: doc/BRIEF.md
# Byte-wide EPROM mode controller

This block is a synthesizable behavioural model of a byte-wide, electrically erasable EPROM together with the decoding of its control pins. The pin levels select the operation. Chip enable, output enable and the program strobe are all active low. Two further inputs are digital flags: one stands for a raised programming supply, and one stands for a high voltage on address line 9. The combination of these levels picks read, verify, program, erase, inhibit or an illegal combination. Nothing is written through a plain write-enable. A program operation can only clear bits. An erase only sets them.

The storage is a register array. Its depth is set by a parameter so that simulation can use a small memory. The incoming address is folded onto that depth by keeping its low bits. Address and data are captured when the strobe falls while the chip is selected. The write is committed at the clock edge where the strobe is first seen high again, and only if the conditions for the chosen operation held for the whole pulse. A strobe pulse that is taken while output enable is low raises a sticky mode-error flag and leaves the array untouched.

Top module: `eprom_ctrl_top`

## Requirements
- R1: A strobe pulse taken with ceN=0, oeN=1, vppHigh=1 and a9High=1 throughout the pulse sets every byte of the array to 8'hFF when the pulse ends.
- R2: A strobe pulse taken with ceN=0, oeN=1, vppHigh=1 and a9High=0 throughout the pulse replaces the addressed byte with the bitwise AND of its old value and the data. A program operation never changes a 0 bit to 1.
- R3: dataOutEn is 1 exactly when ceN=0, oeN=0 and pgmN=1. While dataOutEn is 0, dataOut is 8'h00.
- R4: With vppHigh=0 (read), the enabled output carries the byte stored at the address. Only the low MEM_AW address bits are used, so addresses that differ only above bit MEM_AW-1 read the same byte.
- R5: With vppHigh=1 (verify), the enabled output carries the stored byte in the same way as a read.
- R6: A strobe pulse does not change the array if vppHigh is 0 at its falling edge. It also leaves the array unchanged if vppHigh, oeN, ceN or a9High leaves the value the operation needs at any clock during the pulse, including the clock at which the strobe rises.
- R7: While ceN=1, strobe pulses have no effect on the array (inhibit), so several devices can share every other input.
- R8: If ceN=0, oeN=0 and pgmN=0 at a clock edge, modeErr reads 1 after that edge, and that pulse does not change the array. modeErr stays 1 until a later strobe falling edge with ceN=0 and oeN=1.
- R9: After reset, every byte of the array is 8'hFF and modeErr is 0.
- R10: Address and data are the values present at the clock where the strobe is first seen low. The new byte value is visible on the first read after the clock edge at which the strobe is first seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| addrIn | input | ADDR_W (18) | Byte address |
| dataIn | input | DATA_W (8) | Data to program |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| pgmN | input | 1 | Program strobe, active low |
| vppHigh | input | 1 | Programming supply raised |
| a9High | input | 1 | High voltage on address line 9 (selects erase) |
| dataOut | output | DATA_W (8) | Output data, zero when not driven |
| dataOutEn | output | 1 | Output buffer enable |
| modeErr | output | 1 | Sticky illegal-mode flag |

## Verification
The programming tests use data patterns that clear different sets of bits. One of them programs the same byte twice with overlapping masks, which shows an AND apart from a plain overwrite. Data and address are changed while the strobe is low, which shows whether they are captured at the falling edge or taken at the rising edge. Aliased addresses above the array depth, pulses with chip enable high, pulses with the supply low, and pulses whose supply drops midway are each followed by a read-back, which shows that each of these stimuli was ignored. An erase after a mix of programmed bytes is read back at several addresses, and a pulse taken with output enable low is followed by a read of its target, which separates a flagged error from a silent write.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  // Strobes handed from the mode control to the datapath
  typedef struct packed {
    logic capture;    // latch address and data (strobe fell, chip selected)
    logic doProgram;  // AND latched data into latched byte
    logic doErase;    // fill the whole array with ones
    logic readEn;     // drive the addressed byte onto the outputs
  } eprom_strobe_t;

endpackage

// File: rtl/eprom_mode_ctrl.sv
module eprom_mode_ctrl
  import eprom_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          ceN,
  input  logic          oeN,
  input  logic          pgmN,
  input  logic          vppHigh,
  input  logic          a9High,
  output eprom_strobe_t strb,
  output logic          modeErr
);

  logic pgmPrev;
  logic fallEdge;
  logic riseEdge;
  logic pending;
  logic pendErase;
  logic holdOk;
  logic errNow;
  logic clearNow;

  assign fallEdge = pgmPrev && !pgmN;
  assign riseEdge = !pgmPrev && pgmN;

  // conditions required to keep a started operation alive
  assign holdOk = !ceN && oeN && vppHigh && (a9High == pendErase);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgmPrev <= 1'b1;
    end else begin
      pgmPrev <= pgmN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      pendErase <= 1'b0;
    end else if (fallEdge && !ceN) begin
      pending   <= oeN && vppHigh;
      pendErase <= a9High;
    end else if (pending && (riseEdge || !holdOk)) begin
      pending   <= 1'b0;
    end
  end

  always_comb begin
    strb           = '0;
    strb.capture   = fallEdge && !ceN;
    strb.doProgram = pending && riseEdge && holdOk && !pendErase;
    strb.doErase   = pending && riseEdge && holdOk && pendErase;
    strb.readEn    = !ceN && !oeN && pgmN;
  end

  assign errNow   = !ceN && !oeN && !pgmN;
  assign clearNow = fallEdge && !ceN && oeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeErr <= 1'b0;
    end else if (errNow) begin
      modeErr <= 1'b1;
    end else if (clearNow) begin
      modeErr <= 1'b0;
    end
  end

  AST_INHIBIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> !(strb.doProgram || strb.doErase)); // R7

  AST_LOW_VPP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !vppHigh |-> !(strb.doProgram || strb.doErase)); // R6

  AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && !pgmN) |=> modeErr); // R8

endmodule

// File: rtl/eprom_datapath.sv
module eprom_datapath
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  eprom_strobe_t     strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] memQ [DEPTH];
  logic [MEM_AW-1:0] latAddr;
  logic [DATA_W-1:0] latData;
  logic [MEM_AW-1:0] rdAddr;
  logic              unusedAddrBits;

  assign rdAddr = addrIn[MEM_AW-1:0];

  // address bits above the array depth are deliberately folded away
  generate
    if (MEM_AW < ADDR_W) begin : g_fold
      assign unusedAddrBits = ^addrIn[ADDR_W-1:MEM_AW];
    end else begin : g_full
      assign unusedAddrBits = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr <= '0;
      latData <= '0;
    end else if (strb.capture) begin
      latAddr <= rdAddr;
      latData <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memQ[i] <= '1;
    end else if (strb.doErase) begin
      for (int i = 0; i < DEPTH; i++) memQ[i] <= '1;
    end else if (strb.doProgram) begin
      memQ[latAddr] <= memQ[latAddr] & latData;
    end
  end

  assign dataOutEn = strb.readEn;
  assign dataOut   = strb.readEn ? memQ[rdAddr] : '0;

  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.doProgram |=> ((memQ[$past(latAddr)] & ~$past(memQ[latAddr])) == '0)); // R2

  AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    strb.doErase |=> ((memQ[0] == '1) && (memQ[DEPTH-1] == '1))); // R1

endmodule

// File: rtl/eprom_ctrl_top.sv
module eprom_ctrl_top
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              vppHigh,
  input  logic              a9High,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              modeErr
);

  eprom_strobe_t strb;

  eprom_mode_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .oeN     (oeN),
    .pgmN    (pgmN),
    .vppHigh (vppHigh),
    .a9High  (a9High),
    .strb    (strb),
    .modeErr (modeErr)
  );

  eprom_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MEM_AW (MEM_AW)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addrIn    (addrIn),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn)
  );

  AST_OUT_OFF_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |-> (!dataOutEn && dataOut == '0)); // R3

endmodule

// File: tb/eprom_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module eprom_ctrl_top_tb_top;

  localparam int AW    = 18;
  localparam int DW    = 8;
  localparam int MAW   = 6;
  localparam int DEPTH = 1 << MAW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic ceN = 1'b1, oeN = 1'b1, pgmN = 1'b1, vppHigh = 1'b0, a9High = 1'b0;
  logic [DW-1:0] dataOut;
  logic          dataOutEn, modeErr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eprom_ctrl_top #(.ADDR_W(AW), .DATA_W(DW), .MEM_AW(MAW)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn),
    .ceN(ceN), .oeN(oeN), .pgmN(pgmN), .vppHigh(vppHigh), .a9High(a9High),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .modeErr(modeErr)
  );

  // behavioural reference state
  logic [7:0] mMem [DEPTH];
  bit mPrev, mPend, mPendErase, mErr;
  int mLatA;
  logic [7:0] mLatD;

  task automatic modelReset();
    for (int i = 0; i < DEPTH; i++) mMem[i] = 8'hFF;
    mPrev = 1; mPend = 0; mPendErase = 0; mErr = 0; mLatA = 0; mLatD = 0;
  endtask

  task automatic modelClock(input bit ce, oe, pgm, vpp, a9, input int a, input logic [7:0] d);
    bit fall, rise, ok;
    fall = mPrev && !pgm;
    rise = !mPrev && pgm;
    ok = !ce && oe && vpp && (a9 == mPendErase);
    if (mPend && rise && ok) begin
      if (mPendErase) begin
        for (int i = 0; i < DEPTH; i++) mMem[i] = 8'hFF;
      end else begin
        mMem[mLatA] = mMem[mLatA] & mLatD;
      end
    end
    if (fall && !ce) begin
      mPend = oe && vpp; mPendErase = a9; mLatA = a % DEPTH; mLatD = d;
    end else if (mPend && (rise || !ok)) begin
      mPend = 0;
    end
    if (!ce && !oe && !pgm) mErr = 1;
    else if (fall && !ce && oe) mErr = 0;
    mPrev = pgm;
  endtask

  // one clock: drive, compare outputs, then advance the model at the edge
  task automatic step(input bit ce, oe, pgm, vpp, a9, input int a, input logic [7:0] d, input string tag);
    bit expEn;
    logic [7:0] expOut;
    @(negedge clk);
    ceN = ce; oeN = oe; pgmN = pgm; vppHigh = vpp; a9High = a9;
    addrIn = AW'(a); dataIn = d;
    #1;
    expEn = !ce && !oe && pgm;
    expOut = expEn ? mMem[a % DEPTH] : 8'h00;
    checks++;
    if (dataOutEn !== expEn || dataOut !== expOut || modeErr !== mErr) begin
      failures++;
      $display("FAIL %s: en/out/err actual=%0b/%02h/%0b expected=%0b/%02h/%0b",
               tag, dataOutEn, dataOut, modeErr, expEn, expOut, mErr);
    end
    @(posedge clk);
    modelClock(ce, oe, pgm, vpp, a9, a, d);
  endtask

  task automatic readAt(input int a, input bit vpp, input string tag);
    step(0, 0, 1, vpp, 0, a, 8'h00, tag);
  endtask

  // setup, two low cycles, release
  task automatic pulse(input bit ce, oe, vpp, a9, input int a, input logic [7:0] d, input string tag);
    step(ce, oe, 1, vpp, a9, a, d, tag);
    step(ce, oe, 0, vpp, a9, a, d, tag);
    step(ce, oe, 0, vpp, a9, a, d, tag);
    step(ce, oe, 1, vpp, a9, a, d, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R9: reset state, all bytes erased, no error
    step(1, 1, 1, 0, 0, 0, 8'h00, "R9");
    for (int i = 0; i < DEPTH; i++) readAt(i, 0, "R9");

    // R3: output gating across pin combinations
    step(1, 0, 1, 0, 0, 3, 8'h00, "R3");
    step(0, 1, 1, 0, 0, 3, 8'h00, "R3");
    step(1, 1, 0, 0, 0, 3, 8'h00, "R3");

    // R2 / R5 / R4: program then verify and read
    pulse(0, 1, 1, 0, 5, 8'hA5, "R2");
    readAt(5, 1, "R5");
    readAt(5, 0, "R4");
    pulse(0, 1, 1, 0, 5, 8'h0F, "R2");
    readAt(5, 0, "R2");
    // R4: alias above the array depth
    readAt(5 + DEPTH, 0, "R4");
    readAt(5 + 4 * DEPTH, 1, "R4");

    // R10: address/data changed while low are ignored; visible right after release
    step(0, 1, 1, 1, 0, 12, 8'h3C, "R10");
    step(0, 1, 0, 1, 0, 12, 8'h3C, "R10");
    step(0, 1, 0, 1, 0, 13, 8'h00, "R10");
    step(0, 1, 1, 1, 0, 13, 8'h00, "R10");
    readAt(12, 0, "R10");
    readAt(13, 0, "R10");

    // R7: inhibit with chip enable high
    pulse(1, 1, 1, 0, 7, 8'h00, "R7");
    readAt(7, 0, "R7");
    pulse(1, 1, 1, 1, 0, 8'h00, "R7");
    readAt(5, 0, "R7");

    // R6: supply low, and supply dropping mid-pulse
    pulse(0, 1, 0, 0, 8, 8'h00, "R6");
    readAt(8, 0, "R6");
    step(0, 1, 1, 1, 0, 8, 8'h11, "R6");
    step(0, 1, 0, 1, 0, 8, 8'h11, "R6");
    step(0, 1, 0, 0, 0, 8, 8'h11, "R6");
    step(0, 1, 1, 1, 0, 8, 8'h11, "R6");
    readAt(8, 0, "R6");
    // a9 changes mid-pulse
    step(0, 1, 1, 1, 0, 9, 8'h22, "R6");
    step(0, 1, 0, 1, 0, 9, 8'h22, "R6");
    step(0, 1, 0, 1, 1, 9, 8'h22, "R6");
    step(0, 1, 1, 1, 1, 9, 8'h22, "R6");
    readAt(9, 0, "R6");

    // R8: strobe with output enable low
    pulse(0, 0, 1, 0, 10, 8'h00, "R8");
    readAt(10, 0, "R8");
    readAt(10, 1, "R8");
    pulse(0, 1, 1, 0, 11, 8'hF0, "R8");
    readAt(11, 0, "R8");

    // R2: several data patterns
    for (int k = 0; k < 8; k++) begin
      pulse(0, 1, 1, 0, 20 + k, 8'((k * 37 + 91) ^ (k << 4)), "R2");
      readAt(20 + k, 1, "R2");
    end

    // R1: whole-array erase
    pulse(0, 1, 1, 1, 33, 8'h00, "R1");
    for (int i = 0; i < DEPTH; i += 7) readAt(i, 0, "R1");
    readAt(DEPTH - 1, 1, "R1");

    step(1, 1, 1, 0, 0, 0, 8'h00, "R3");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule